// File: doc/BRIEF.md
# Multidimensional Matrix Index Remapper

This block turns a plain run of loop steps into a walk over a one-, two- or three-dimensional array. A 32-bit shape word sets three axis lengths, the nesting order of the three loops, a count-down option for each axis, a choice of one axis to leave out of the index, and a small constant added to every result. A start pulse loads the shape word and a run length. After that, each step pulse yields the next element index on a registered output, marked by a one-cycle valid flag. A done flag marks the last step of the run.

The three axis counters form a chain of mixed-radix digits. The innermost axis advances on every step, and each counter carries into the next one in the chosen nesting order. Per-axis strides are worked out once, when the shape is loaded. Each index is then the sum of the counter values times their strides, plus the constant. A shape word of all zeros bypasses the counters, and the index is then the step number itself.

Top module: `matrix_index_remapper`

## Requirements
- R1: After reset, idx_o is 0, valid_o is 0, done_o is 0, unsup_o is 0 and total_o is 1.
- R2: The shape word fields are: X size in bits 5:0, Y size in bits 11:6, Z size in bits 17:12, order code in bits 20:18, count-down bits in 23:21 (bit 21 for X, bit 22 for Y, bit 23 for Z), add constant in bits 27:24, drop code in bits 29:28, and reserved bits 31:30. Each size field holds the axis length minus one, so a length need not be a power of two. The cycle after start_i, total_o equals the product of the three axis lengths.
- R3: A step_i pulse taken while start_i is low and the shape is supported makes valid_o 1 in the next cycle, with idx_o holding the index of the position before the advance. With no step, valid_o is 0 in the next cycle.
- R4: Order codes 0 to 5 set the loop nesting, innermost axis first, as X-Y-Z, X-Z-Y, Y-X-Z, Y-Z-X, Z-X-Y and Z-Y-X. The innermost axis moves on every step and carries outward when it wraps.
- R5: An axis whose count-down bit is set starts at its length minus one and counts down to 0. An axis whose bit is clear starts at 0 and counts up.
- R6: Drop code 0 gives index X + Y*Xlen + Z*Xlen*Ylen. Code 1 drops X and gives Y + Z*Ylen. Code 2 drops Y and gives X + Z*Xlen. Code 3 drops Z and gives X + Y*Xlen.
- R7: The add constant is added to every index after remapping.
- R8: An all-zero shape word makes idx_o equal the step number within the run, counted from 0.
- R9: The run length len_i (1 to 127, where 0 acts as 1) is latched at start. On the step that completes the run, done_o rises together with valid_o for one cycle, and the next step starts again from the first position.
- R10: An order code of 6 or 7, or a nonzero reserved field, sets unsup_o, and step pulses then produce no valid_o until a supported shape is loaded.
- R11: When start_i and step_i are high in the same cycle, the step is ignored and the run restarts at its first position with the new shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load shape and length, restart the walk |
| shape_i | input | 32 | Shape word |
| len_i | input | LEN_W | Steps in one run |
| step_i | input | 1 | Advance one element |
| idx_o | output | IDX_W | Remapped element index |
| valid_o | output | 1 | idx_o updated this cycle |
| done_o | output | 1 | Last step of the run |
| total_o | output | PROD_W | Product of the three axis lengths |
| unsup_o | output | 1 | Loaded shape is not a matrix shape |

## Verification
The hardest case to reach is a carry that ripples through all three counters when axes count down and the nesting is permuted. That case only occurs after many steps, on the exact step where two counters wrap together. The vector table therefore holds three-dimensional shapes with mixed count-down bits and non-identity orders, and runs each one past its full length, so that every wrap and the restart after done are observed. A run length shorter than the array and one longer than it check that the run counter and the geometry wrap independently. Start arriving on top of a step in the middle of a run is driven directly.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DIM_W  = 6;
  localparam int OFF_W  = 4;
  localparam int NAX    = 3;
  localparam int PROD_W = NAX * DIM_W + 1;
  localparam int IDX_W  = PROD_W + 1;

  typedef struct packed {
    logic [1:0]       rsvd;
    logic [1:0]       drop;
    logic [OFF_W-1:0] add;
    logic [2:0]       down;
    logic [2:0]       order;
    logic [DIM_W-1:0] zs;
    logic [DIM_W-1:0] ys;
    logic [DIM_W-1:0] xs;
  } shape_t;

  typedef enum logic [1:0] {
    DROP_NONE = 2'd0,
    DROP_X    = 2'd1,
    DROP_Y    = 2'd2,
    DROP_Z    = 2'd3
  } drop_e;

  // axis id placed at nesting level lvl (0 = innermost)
  function automatic logic [1:0] axis_at(input logic [2:0] order, input int lvl);
    logic [5:0] seq;
    case (order)
      3'd0:    seq = {2'd2, 2'd1, 2'd0};
      3'd1:    seq = {2'd1, 2'd2, 2'd0};
      3'd2:    seq = {2'd2, 2'd0, 2'd1};
      3'd3:    seq = {2'd0, 2'd2, 2'd1};
      3'd4:    seq = {2'd1, 2'd0, 2'd2};
      default: seq = {2'd0, 2'd1, 2'd2};
    endcase
    return seq[lvl*2 +: 2];
  endfunction
endpackage

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] size,
  input  logic         inv,
  output logic [W-1:0] cnt,
  output logic         at_end
);
  logic [W-1:0] first;

  assign first  = inv ? size : '0;
  assign at_end = inv ? (cnt == '0) : (cnt == size);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= first;
    else if (tick) begin
      if (at_end)       cnt <= first;
      else if (inv)     cnt <= cnt - 1'b1;
      else              cnt <= cnt + 1'b1;
    end
  end

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst || load)
    cnt <= size);

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (inv && tick && !load && !at_end) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/remap_geom.sv
module remap_geom
  import remap_pkg::*;
(
  input  logic [DIM_W-1:0]  xs,
  input  logic [DIM_W-1:0]  ys,
  input  logic [DIM_W-1:0]  zs,
  input  logic [1:0]        drop,
  output logic [PROD_W-1:0] w_x,
  output logic [PROD_W-1:0] w_y,
  output logic [PROD_W-1:0] w_z,
  output logic [PROD_W-1:0] total
);
  logic [PROD_W-1:0] lx, ly, lz, lxy;

  always_comb begin
    lx    = PROD_W'(xs) + 1'b1;
    ly    = PROD_W'(ys) + 1'b1;
    lz    = PROD_W'(zs) + 1'b1;
    lxy   = lx * ly;
    total = lxy * lz;
    case (drop_e'(drop))
      DROP_X: begin w_x = '0;  w_y = 1; w_z = ly;  end
      DROP_Y: begin w_x = 1;   w_y = '0; w_z = lx; end
      DROP_Z: begin w_x = 1;   w_y = lx; w_z = '0; end
      default: begin w_x = 1;  w_y = lx; w_z = lxy; end
    endcase
  end
endmodule

// File: rtl/remap_index.sv
module remap_index
  import remap_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic [NAX-1:0][DIM_W-1:0] pos,
  input  logic [PROD_W-1:0]         w_x,
  input  logic [PROD_W-1:0]         w_y,
  input  logic [PROD_W-1:0]         w_z,
  input  logic [OFF_W-1:0]          add,
  input  logic                      linear,
  input  logic [LEN_W-1:0]          step_no,
  output logic [IDX_W-1:0]          idx
);
  logic [IDX_W-1:0] px, py, pz;

  always_comb begin
    px = IDX_W'(pos[0]) * IDX_W'(w_x);
    py = IDX_W'(pos[1]) * IDX_W'(w_y);
    pz = IDX_W'(pos[2]) * IDX_W'(w_z);
    if (linear) idx = IDX_W'(step_no);
    else        idx = px + py + pz + IDX_W'(add);
  end
endmodule

// File: rtl/matrix_index_remapper.sv
module matrix_index_remapper
  import remap_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [31:0]       shape_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o,
  output logic              done_o,
  output logic [PROD_W-1:0] total_o,
  output logic              unsup_o
);
  shape_t sh_new;
  assign sh_new = shape_t'(shape_i);

  logic [NAX-1:0][DIM_W-1:0] dim_q, dim_use, pos;
  logic [2:0]        order_q, down_q, down_use;
  logic [OFF_W-1:0]  add_q;
  logic [LEN_W-1:0]  last_q, step_q, len_m1;
  logic              linear_q;
  logic [PROD_W-1:0] wx_q, wy_q, wz_q, wx_n, wy_n, wz_n, tot_n;
  logic [NAX-1:0]    wrap, tick;
  logic              go, last, restart;
  logic [1:0]        ax0, ax1, ax2;
  logic              c0, c1, c2, w0, w1;
  logic [IDX_W-1:0]  idx_n;

  assign len_m1  = (len_i == '0) ? '0 : len_i - LEN_W'(1);
  assign go      = step_i && !start_i && !unsup_o;
  assign last    = go && (step_q == last_q);
  assign restart = start_i || last;

  assign dim_use  = start_i ? {sh_new.zs, sh_new.ys, sh_new.xs} : dim_q;
  assign down_use = start_i ? sh_new.down : down_q;

  // carry chain in nesting order
  always_comb begin
    ax0 = axis_at(order_q, 0);
    ax1 = axis_at(order_q, 1);
    ax2 = axis_at(order_q, 2);
    w0 = 1'b0;
    w1 = 1'b0;
    for (int a = 0; a < NAX; a++) begin
      if (ax0 == 2'(a)) w0 = wrap[a];
      if (ax1 == 2'(a)) w1 = wrap[a];
    end
    c0 = go;
    c1 = c0 && w0;
    c2 = c1 && w1;
    for (int a = 0; a < NAX; a++) begin
      if (ax0 == 2'(a))      tick[a] = c0;
      else if (ax1 == 2'(a)) tick[a] = c1;
      else if (ax2 == 2'(a)) tick[a] = c2;
      else                   tick[a] = 1'b0;
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    remap_axis_ctr #(.W(DIM_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .load   (restart),
      .tick   (tick[a]),
      .size   (dim_use[a]),
      .inv    (down_use[a]),
      .cnt    (pos[a]),
      .at_end (wrap[a])
    );
  end

  remap_geom u_geom (
    .xs    (sh_new.xs),
    .ys    (sh_new.ys),
    .zs    (sh_new.zs),
    .drop  (sh_new.drop),
    .w_x   (wx_n),
    .w_y   (wy_n),
    .w_z   (wz_n),
    .total (tot_n)
  );

  remap_index #(.LEN_W(LEN_W)) u_idx (
    .pos     (pos),
    .w_x     (wx_q),
    .w_y     (wy_q),
    .w_z     (wz_q),
    .add     (add_q),
    .linear  (linear_q),
    .step_no (step_q),
    .idx     (idx_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dim_q    <= '0;
      order_q  <= '0;
      down_q   <= '0;
      add_q    <= '0;
      last_q   <= '0;
      step_q   <= '0;
      linear_q <= 1'b1;
      wx_q     <= PROD_W'(1);
      wy_q     <= PROD_W'(1);
      wz_q     <= PROD_W'(1);
      total_o  <= PROD_W'(1);
      unsup_o  <= 1'b0;
      idx_o    <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= go;
      done_o  <= last;
      if (go) idx_o <= idx_n;
      if (restart)  step_q <= '0;
      else if (go)  step_q <= step_q + 1'b1;
      if (start_i) begin
        dim_q    <= {sh_new.zs, sh_new.ys, sh_new.xs};
        order_q  <= sh_new.order;
        down_q   <= sh_new.down;
        add_q    <= sh_new.add;
        last_q   <= len_m1;
        linear_q <= (shape_i == 32'd0);
        unsup_o  <= (sh_new.order[2:1] == 2'b11) || (sh_new.rsvd != 2'b00);
        wx_q     <= wx_n;
        wy_q     <= wy_n;
        wz_q     <= wz_n;
        total_o  <= tot_n;
      end
    end
  end

  // R9
  done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> valid_o);

  // R9
  run_bound_chk: assert property (@(posedge clk) disable iff (rst || start_i)
    step_q <= last_q);

  // R10
  unsup_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (unsup_o && !start_i) |=> !valid_o);

  // R11
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !valid_o);

  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(step_i));
endmodule

// File: tb/sim_matrix_index_remapper.sv
module sim_matrix_index_remapper;
  import remap_pkg::*;
  localparam int LEN_W = 7;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] shape_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic step_i = 1'b0;
  logic [IDX_W-1:0] idx_o;
  logic valid_o, done_o, unsup_o;
  logic [PROD_W-1:0] total_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  matrix_index_remapper #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .shape_i(shape_i), .len_i(len_i),
    .step_i(step_i), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o),
    .total_o(total_o), .unsup_o(unsup_o)
  );

  // {len, shape}: shape = {rsvd2, drop2, add4, down3, order3, zs6, ys6, xs6}
  localparam logic [38:0] VEC [NV] = '{
    {7'd6,  2'd0, 2'd0, 4'd0, 3'b000, 3'd0, 6'd0, 6'd1, 6'd2},
    {7'd6,  2'd0, 2'd0, 4'd0, 3'b000, 3'd2, 6'd0, 6'd1, 6'd2},
    {7'd10, 2'd0, 2'd0, 4'd5, 3'b101, 3'd5, 6'd1, 6'd1, 6'd1},
    {7'd9,  2'd0, 2'd1, 4'd0, 3'b000, 3'd0, 6'd0, 6'd2, 6'd2},
    {7'd9,  2'd0, 2'd2, 4'd0, 3'b000, 3'd0, 6'd0, 6'd2, 6'd2},
    {7'd5,  32'd0},
    {7'd20, 2'd0, 2'd3, 4'd3, 3'b010, 3'd3, 6'd1, 6'd2, 6'd4},
    {7'd7,  2'd0, 2'd0, 4'd0, 3'b000, 3'd0, 6'd0, 6'd0, 6'd2}
  };

  function automatic int exp_idx(input logic [31:0] sh, input int k);
    int sz[3]; int ln[3]; int ord[3]; int v[3];
    int tot, rem, dg, wx, wy, wz;
    if (sh == 32'd0) return k;
    sz[0] = int'(sh[5:0]); sz[1] = int'(sh[11:6]); sz[2] = int'(sh[17:12]);
    for (int a = 0; a < 3; a++) ln[a] = sz[a] + 1;
    case (sh[20:18])
      3'd0: ord = '{0, 1, 2};
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    tot = ln[0] * ln[1] * ln[2];
    rem = k % tot;
    for (int l = 0; l < 3; l++) begin
      dg = rem % ln[ord[l]];
      rem = rem / ln[ord[l]];
      v[ord[l]] = sh[21 + ord[l]] ? sz[ord[l]] - dg : dg;
    end
    case (sh[29:28])
      2'd1: begin wx = 0; wy = 1; wz = ln[1]; end
      2'd2: begin wx = 1; wy = 0; wz = ln[0]; end
      2'd3: begin wx = 1; wy = ln[0]; wz = 0; end
      default: begin wx = 1; wy = ln[0]; wz = ln[0] * ln[1]; end
    endcase
    return v[0] * wx + v[1] * wy + v[2] * wz + int'(sh[27:24]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] sh, input logic [LEN_W-1:0] ln);
    @(negedge clk);
    start_i = 1'b1; shape_i = sh; len_i = ln; step_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 idx", int'(idx_o), 0);
    check("R1 valid", int'(valid_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 unsup", int'(unsup_o), 0);
    check("R1 total", int'(total_o), 1);

    // R2 R4 R5 R6 R7 R8 R9 vector table
    for (int v = 0; v < NV; v++) begin
      logic [31:0] sh;
      int ln, le, tot;
      sh = VEC[v][31:0];
      ln = int'(VEC[v][38:32]);
      le = (ln == 0) ? 1 : ln;
      tot = (int'(sh[5:0]) + 1) * (int'(sh[11:6]) + 1) * (int'(sh[17:12]) + 1);
      load(sh, LEN_W'(ln));
      check("R2 total", int'(total_o), tot);
      check("R10 unsup clear", int'(unsup_o), 0);
      step_i = 1'b1;
      for (int i = 0; i < le + 2; i++) begin
        @(negedge clk);
        check("R4 R5 R6 R7 R8 idx", int'(idx_o), exp_idx(sh, i % le));
        check("R3 valid", int'(valid_o), 1);
        check("R9 done", int'(done_o), (i % le == le - 1) ? 1 : 0);
      end
      step_i = 1'b0;
      @(negedge clk);
      check("R3 idle valid", int'(valid_o), 0);
    end

    // R10 unsupported order code and reserved bits
    load({2'd0, 2'd0, 4'd0, 3'd0, 3'd6, 6'd0, 6'd1, 6'd2}, 7'd6);
    check("R10 unsup order6", int'(unsup_o), 1);
    step_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 no valid", int'(valid_o), 0);
    end
    step_i = 1'b0;
    load({2'd1, 2'd0, 4'd0, 3'd0, 3'd0, 6'd0, 6'd1, 6'd2}, 7'd6);
    check("R10 unsup rsvd", int'(unsup_o), 1);

    // R11 start on top of a step
    load({2'd0, 2'd0, 4'd0, 3'd0, 3'd0, 6'd0, 6'd1, 6'd2}, 7'd6);
    step_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 before idx", int'(idx_o), 1);
    start_i = 1'b1; shape_i = 32'd0; len_i = 7'd4;
    @(negedge clk);
    start_i = 1'b0; step_i = 1'b0;
    check("R11 step ignored", int'(valid_o), 0);
    step_i = 1'b1;
    @(negedge clk);
    check("R11 restart idx", int'(idx_o), 0);
    check("R11 restart valid", int'(valid_o), 1);
    @(negedge clk);
    step_i = 1'b0;
    check("R8 linear idx", int'(idx_o), 1);

    // R9 length 0 acts as 1
    load({2'd0, 2'd0, 4'd0, 3'd0, 3'd0, 6'd0, 6'd0, 6'd2}, 7'd0);
    step_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 len0 idx", int'(idx_o), 0);
      check("R9 len0 done", int'(done_o), 1);
    end
    step_i = 1'b0;

    // R1 reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rerun idx", int'(idx_o), 0);
    check("R1 rerun total", int'(total_o), 1);
    check("R1 rerun done", int'(done_o), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule